// File: doc/BRIEF.md
# Supply Mode Sequencer with Rail Hopping

This block governs the supply and clock of one locally clocked domain. Software picks one of six operating modes by writing a register over a simple write/read bus. The block then drives two power-switch enables, one for the high-voltage rail and one for the low-voltage rail. It also drives a clock-run enable, a reset hold for the domain, and a pause request to the domain's pausable clock generator.

Every rail change is done inside a pause of the local clock. The block raises the pause request and waits for the generator to grant it. It closes the incoming switch while the outgoing one is still closed, then opens the outgoing switch. It then waits a programmed number of settle cycles before it drops the request.

In the hopping mode a pulse-width modulator with programmable period and high-phase length chooses between the two rails. This sets the domain's average speed and power. The block has no data stream: all pins are plain control and status, and the bus has no back-pressure, since a write takes effect in the cycle it is presented.

Top module: `pmm_top`

## Requirements
- R1: After reset the mode is Init (code 0), the high switch is closed and the low switch open, the domain reset and the clock-run enable are high, the pause request is low and the error bit is clear.
- R2: The switch enables change only while the pause request is high. While the request waits for a grant, neither switch enable moves.
- R3: The switches never swap directly from high-only to low-only or the reverse. Both are closed for at least one cycle in between.
- R4: After the outgoing switch opens, the pause request stays high for exactly settle+1 cycles, where settle is the value in register 3.
- R5: Mode codes: Init=0, High=1, Low=2, Hopping=3, Idle=4, Off=5. Init and High settle on the high rail only, and Low settles on the low rail only. The clock runs in all three.
- R6: Idle settles on the low rail with clock-run low. Off settles with both switches open and clock-run low.
- R7: In Hopping, a high-phase length (register 2) of zero keeps the low rail. A length equal to or above the period (register 1) keeps the high rail.
- R8: In Hopping, a high-phase length strictly between zero and the period makes the domain alternate between the high and low rails.
- R9: A mode write (register 0) with code 6 or 7, or from Off to any mode other than Init, leaves the mode unchanged and sets the error bit.
- R10: The error bit stays set until a write to register 4 with bit 4 set clears it.
- R11: Reading register 4 returns the mode in bits 2:0, rail transition in progress (the pause request) in bit 3 and the error bit in bit 4. Registers 1, 2, 3 and 5 read back the last value written, and register 5 drives the delay-line configuration output.
- R12: The domain reset output is high exactly while the mode is Init.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe for the register bus |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr (combinational) |
| pause_gnt | input | 1 | Pause grant from the clock generator |
| pause_req | output | 1 | Pause request to the clock generator |
| sw_hi_en | output | 1 | High-rail power switch enable |
| sw_lo_en | output | 1 | Low-rail power switch enable |
| clk_run | output | 1 | Local clock run enable |
| dom_rst | output | 1 | Reset hold for the domain |
| dly_cfg | output | 16 | Delay-line configuration value |

## Verification
The bound checker checks on every cycle that switch enables move only under a pause request and stay frozen while a grant is awaited. It also checks that the rails never swap without an overlap, and that a rejected mode write leaves the mode alone and raises the error bit. Only the bench scenarios can show the final rail and clock state of each mode and the exact settle length. The same holds for the rail pattern under the three duty regimes and the behaviour of the error bit across clearing and register readback.

// File: rtl/pmm_pkg.sv
package pmm_pkg;
  typedef enum logic [2:0] {
    M_INIT = 3'd0,
    M_HIGH = 3'd1,
    M_LOW  = 3'd2,
    M_HOP  = 3'd3,
    M_IDLE = 3'd4,
    M_OFF  = 3'd5
  } mode_t;

  localparam int A_MODE   = 0;
  localparam int A_PERIOD = 1;
  localparam int A_DUTY   = 2;
  localparam int A_SETTLE = 3;
  localparam int A_STAT   = 4;
  localparam int A_DLY    = 5;

  localparam logic [1:0] RAIL_NONE = 2'b00;
  localparam logic [1:0] RAIL_LO   = 2'b01;
  localparam logic [1:0] RAIL_HI   = 2'b10;

  function automatic logic mode_ok(input logic [2:0] cur, input logic [2:0] nxt);
    if (nxt > 3'd5) return 1'b0;
    if (cur == 3'd5 && nxt != 3'd0) return 1'b0;
    return 1'b1;
  endfunction
endpackage

// File: rtl/pmm_regs.sv
module pmm_regs
  import pmm_pkg::*;
#(
  parameter int DW = 16,
  parameter int AW = 3,
  parameter int RST_PERIOD = 16,
  parameter int RST_DUTY = 8,
  parameter int RST_SETTLE = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  input  logic          busy,
  output mode_t         mode,
  output logic [DW-1:0] period,
  output logic [DW-1:0] duty,
  output logic [DW-1:0] settle,
  output logic [DW-1:0] dly,
  output logic          err,
  output logic [DW-1:0] rdata
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode   <= M_INIT;
      period <= DW'(RST_PERIOD);
      duty   <= DW'(RST_DUTY);
      settle <= DW'(RST_SETTLE);
      dly    <= '0;
      err    <= 1'b0;
    end else if (bus_wr) begin
      case (bus_addr)
        AW'(A_MODE): begin
          if (mode_ok(mode, bus_wdata[2:0])) mode <= mode_t'(bus_wdata[2:0]);
          else err <= 1'b1;
        end
        AW'(A_PERIOD): period <= bus_wdata;
        AW'(A_DUTY):   duty   <= bus_wdata;
        AW'(A_SETTLE): settle <= bus_wdata;
        AW'(A_STAT):   if (bus_wdata[4]) err <= 1'b0;
        AW'(A_DLY):    dly    <= bus_wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    rdata = '0;
    case (bus_addr)
      AW'(A_MODE):   rdata[2:0] = mode;
      AW'(A_PERIOD): rdata = period;
      AW'(A_DUTY):   rdata = duty;
      AW'(A_SETTLE): rdata = settle;
      AW'(A_STAT): begin
        rdata[2:0] = mode;
        rdata[3]   = busy;
        rdata[4]   = err;
      end
      AW'(A_DLY):    rdata = dly;
      default: ;
    endcase
  end
endmodule

// File: rtl/pmm_pwm.sv
module pmm_pwm #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [DW-1:0] period,
  input  logic [DW-1:0] duty,
  output logic          hi
);
  logic [DW-1:0] cnt;
  logic [DW:0]   cnt_inc;

  assign cnt_inc = {1'b0, cnt} + {{DW{1'b0}}, 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         cnt <= '0;
    else if (!en)                       cnt <= '0;
    else if (cnt_inc >= {1'b0, period}) cnt <= '0;
    else                                cnt <= cnt_inc[DW-1:0];
  end

  assign hi = en && (cnt < duty);
endmodule

// File: rtl/pmm_seq.sv
module pmm_seq
  import pmm_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    want,
  input  logic [DW-1:0] settle,
  input  logic          pause_gnt,
  output logic [1:0]    sw,
  output logic          pause_req,
  output logic          waiting
);
  typedef enum logic [1:0] {S_IDLE, S_REQ, S_MAKE, S_SETTLE} st_t;
  st_t           st;
  logic [1:0]    tgt;
  logic [DW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= S_IDLE;
      sw  <= RAIL_HI;
      tgt <= RAIL_HI;
      cnt <= '0;
    end else begin
      case (st)
        S_IDLE: if (want != sw) begin
          tgt <= want;
          st  <= S_REQ;
        end
        S_REQ: if (pause_gnt) begin
          sw <= sw | tgt;
          st <= S_MAKE;
        end
        S_MAKE: begin
          sw  <= tgt;
          cnt <= settle;
          st  <= S_SETTLE;
        end
        S_SETTLE: begin
          if (cnt == '0) st <= S_IDLE;
          else           cnt <= cnt - 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign pause_req = (st != S_IDLE);
  assign waiting   = (st == S_REQ);
endmodule

// File: rtl/pmm_top.sv
module pmm_top
  import pmm_pkg::*;
#(
  parameter int DW = 16,
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic          pause_gnt,
  output logic          pause_req,
  output logic          sw_hi_en,
  output logic          sw_lo_en,
  output logic          clk_run,
  output logic          dom_rst,
  output logic [DW-1:0] dly_cfg
);
  mode_t         mode_q;
  logic [DW-1:0] period, duty, settle;
  logic          err_q, hop_hi, seq_wait;
  logic [1:0]    want, sw;

  pmm_regs #(.DW(DW), .AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .busy(pause_req), .mode(mode_q),
    .period(period), .duty(duty), .settle(settle), .dly(dly_cfg),
    .err(err_q), .rdata(bus_rdata)
  );

  pmm_pwm #(.DW(DW)) u_pwm (
    .clk(clk), .rst_n(rst_n), .en(mode_q == M_HOP),
    .period(period), .duty(duty), .hi(hop_hi)
  );

  always_comb begin
    case (mode_q)
      M_INIT, M_HIGH: want = RAIL_HI;
      M_LOW, M_IDLE:  want = RAIL_LO;
      M_HOP:          want = hop_hi ? RAIL_HI : RAIL_LO;
      default:        want = RAIL_NONE;
    endcase
  end

  pmm_seq #(.DW(DW)) u_seq (
    .clk(clk), .rst_n(rst_n), .want(want), .settle(settle),
    .pause_gnt(pause_gnt), .sw(sw), .pause_req(pause_req), .waiting(seq_wait)
  );

  assign sw_hi_en = sw[1];
  assign sw_lo_en = sw[0];
  assign clk_run  = (mode_q inside {M_INIT, M_HIGH, M_LOW, M_HOP}) && (sw != RAIL_NONE);
  assign dom_rst  = (mode_q == M_INIT);
endmodule

// File: rtl/pmm_chk.sv
module pmm_chk
  import pmm_pkg::*;
#(
  parameter int DW = 16,
  parameter int AW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_wr,
  input logic [AW-1:0] bus_addr,
  input logic [DW-1:0] bus_wdata,
  input logic [2:0]    mode_q,
  input logic          err_q,
  input logic          sw_hi_en,
  input logic          sw_lo_en,
  input logic          pause_req,
  input logic          pause_gnt,
  input logic          seq_wait
);
  AST_SW_UNDER_PAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable({sw_hi_en, sw_lo_en}) |-> $past(pause_req)); // R2
  AST_FROZEN_NO_GNT: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_wait && !pause_gnt) |=> $stable({sw_hi_en, sw_lo_en})); // R2
  AST_NO_DIRECT_SWAP: assert property (@(posedge clk) disable iff (!rst_n)
    !(($past({sw_hi_en, sw_lo_en}) == RAIL_HI && {sw_hi_en, sw_lo_en} == RAIL_LO) ||
      ($past({sw_hi_en, sw_lo_en}) == RAIL_LO && {sw_hi_en, sw_lo_en} == RAIL_HI))); // R3
  AST_BAD_MODE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == AW'(A_MODE) && !mode_ok(mode_q, bus_wdata[2:0]))
      |=> ($stable(mode_q) && err_q)); // R9
endmodule

bind pmm_top pmm_chk #(.DW(DW), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .mode_q(mode_q), .err_q(err_q),
  .sw_hi_en(sw_hi_en), .sw_lo_en(sw_lo_en), .pause_req(pause_req),
  .pause_gnt(pause_gnt), .seq_wait(seq_wait)
);

// File: tb/tb_pmm_top.sv
module tb_pmm_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        pause_gnt = 1'b0;
  logic        pause_req, sw_hi_en, sw_lo_en, clk_run, dom_rst;
  logic [15:0] dly_cfg;

  int ntests = 0;
  int nfail = 0;
  logic gnt_allow = 1'b1;
  logic [1:0] gnt_d = '0;
  logic [1:0] prev_sw = 2'b10;
  logic prev_req = 1'b0;
  int bad_nopause = 0;
  int bad_swap = 0;
  int overlap = 0;

  always #5 clk = ~clk;

  pmm_top dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pause_gnt(pause_gnt),
    .pause_req(pause_req), .sw_hi_en(sw_hi_en), .sw_lo_en(sw_lo_en),
    .clk_run(clk_run), .dom_rst(dom_rst), .dly_cfg(dly_cfg)
  );

  // clock-generator model: grants two cycles after a request, driven away from the edge
  always @(negedge clk) begin
    gnt_d     <= {gnt_d[0], pause_req & gnt_allow};
    pause_gnt <= gnt_d[1] & pause_req & gnt_allow;
  end

  // switch monitor for R2 and R3
  always @(negedge clk) begin
    if (rst_n) begin
      if ({sw_hi_en, sw_lo_en} != prev_sw && !prev_req) bad_nopause++;
      if ((prev_sw == 2'b10 && {sw_hi_en, sw_lo_en} == 2'b01) ||
          (prev_sw == 2'b01 && {sw_hi_en, sw_lo_en} == 2'b10)) bad_swap++;
      if (sw_hi_en && sw_lo_en) overlap++;
    end
    prev_sw  <= {sw_hi_en, sw_lo_en};
    prev_req <= pause_req;
  end

  task automatic check(input string tag, input int act, input int exp);
    ntests++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 3'(a); bus_wdata = 16'(d);
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input int a, output int d);
    @(negedge clk);
    bus_addr = 3'(a);
    #1 d = int'(bus_rdata);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // {mode code, expected {hi,lo}, clk_run, dom_rst}
  localparam logic [6:0] VEC [6] = '{
    {3'd1, 2'b10, 1'b1, 1'b0},
    {3'd2, 2'b01, 1'b1, 1'b0},
    {3'd4, 2'b01, 1'b0, 1'b0},
    {3'd1, 2'b10, 1'b1, 1'b0},
    {3'd5, 2'b00, 1'b0, 1'b0},
    {3'd0, 2'b10, 1'b1, 1'b1}
  };

  task automatic report;
    $display("  [TB] %0d tests run, %0d failed", ntests, nfail);
    $finish;
  endtask

  initial begin
    #2_000_000;
    nfail++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    int d, n, hi_n, lo_n;
    idle(3);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 switches", {sw_hi_en, sw_lo_en}, 2'b10);
    check("R1 clk_run", clk_run, 1);
    check("R1 dom_rst R12", dom_rst, 1);
    check("R1 pause_req", pause_req, 0);
    rd(4, d);
    check("R1 status", d, 0);

    // R5 R6 R12 mode table
    foreach (VEC[i]) begin
      wr(0, VEC[i][6:4]);
      idle(30);
      check("R5/R6 switches", {sw_hi_en, sw_lo_en}, VEC[i][3:2]);
      check("R5/R6 clk_run", clk_run, VEC[i][1]);
      check("R12 dom_rst", dom_rst, VEC[i][0]);
      rd(4, d);
      check("R11 status mode", d & 7, VEC[i][6:4]);
    end

    // R9 code 6 from Init rejected
    wr(0, 6);
    rd(4, d);
    check("R9 code6 mode kept", d & 7, 0);
    check("R9 code6 err", (d >> 4) & 1, 1);
    wr(0, 0);
    rd(4, d);
    check("R10 err sticky", (d >> 4) & 1, 1);
    wr(4, 16'h0010);
    rd(4, d);
    check("R10 err cleared", (d >> 4) & 1, 0);

    // R9 Off can only leave to Init
    wr(0, 5);
    idle(20);
    wr(0, 2);
    idle(20);
    rd(4, d);
    check("R9 off->low mode kept", d & 7, 5);
    check("R9 off->low err", (d >> 4) & 1, 1);
    check("R9 off->low switches", {sw_hi_en, sw_lo_en}, 2'b00);
    wr(4, 16'h0010);
    wr(0, 0);
    idle(30);
    check("R9 off->init switches", {sw_hi_en, sw_lo_en}, 2'b10);

    // R2 hold without grant
    gnt_allow = 1'b0;
    wr(0, 2);
    idle(20);
    check("R2 frozen without grant", {sw_hi_en, sw_lo_en}, 2'b10);
    rd(4, d);
    check("R11 busy bit", (d >> 3) & 1, 1);
    gnt_allow = 1'b1;
    idle(30);
    check("R2 moved after grant", {sw_hi_en, sw_lo_en}, 2'b01);
    rd(4, d);
    check("R11 busy clear", (d >> 3) & 1, 0);

    // R4 settle length with settle=5, low -> high
    wr(3, 5);
    wr(0, 1);
    n = 0;
    for (int k = 0; k < 100 && {sw_hi_en, sw_lo_en} != 2'b10; k++) @(negedge clk);
    while (pause_req && n < 100) begin
      n++;
      @(negedge clk);
    end
    check("R4 settle cycles", n, 6);
    rd(3, d);
    check("R11 settle readback", d, 5);

    // R7 R8 hopping
    wr(3, 1);
    wr(1, 10);
    wr(2, 0);
    wr(0, 3);
    idle(30);
    hi_n = 0; lo_n = 0;
    for (int k = 0; k < 60; k++) begin
      @(negedge clk);
      if (sw_hi_en) hi_n++;
      if (sw_lo_en) lo_n++;
    end
    check("R7 duty zero hi", hi_n, 0);
    check("R7 duty zero lo", lo_n, 60);
    wr(2, 10);
    idle(30);
    hi_n = 0; lo_n = 0;
    for (int k = 0; k < 60; k++) begin
      @(negedge clk);
      if (sw_hi_en) hi_n++;
      if (sw_lo_en) lo_n++;
    end
    check("R7 duty full hi", hi_n, 60);
    check("R7 duty full lo", lo_n, 0);
    wr(2, 5);
    hi_n = 0; lo_n = 0;
    for (int k = 0; k < 200; k++) begin
      @(negedge clk);
      if (sw_hi_en && !sw_lo_en) hi_n++;
      if (sw_lo_en && !sw_hi_en) lo_n++;
    end
    check("R8 hop saw high", hi_n > 0, 1);
    check("R8 hop saw low", lo_n > 0, 1);
    rd(1, d);
    check("R11 period readback", d, 10);

    // R11 delay-line register
    wr(5, 16'h1234);
    rd(5, d);
    check("R11 dly readback", d, 16'h1234);
    check("R11 dly port", dly_cfg, 16'h1234);

    wr(0, 5);
    idle(30);
    check("R6 off after hop", {sw_hi_en, sw_lo_en}, 2'b00);

    check("R2 switch moves without pause", bad_nopause, 0);
    check("R3 direct swaps", bad_swap, 0);
    check("R3 overlap seen", overlap > 0, 1);
    report();
  end
endmodule